// File: doc/BRIEF.md
# Doorbell-Driven Descriptor Ring Consumer

This block is the device-side servicing engine for a single one-way channel whose circular descriptor ring lives in host memory. Before use, the host programs a ring base address, a consumer index and a producer index. Later it announces new work by writing a doorbell that carries the updated producer index. The engine compares the two indices. It reads each pending descriptor by address through a request/response memory port and presents it, tagged with its ring index, to a downstream consumer through a valid/ready handshake. Each time a descriptor is accepted, the engine advances its consumer index with wrap-around and pulses a completion strobe.

Indices count ring elements from 0 to `RING_LEN-1`. The byte address of element `i` is `base + i*ELEM_BYTES`. A ring is empty when both indices are equal. It is full when the producer index plus one, wrapped, equals the consumer index, so one slot is never used. Only one memory read is outstanding at any time. Descriptors are serviced strictly in ring order until the consumer index catches up with the producer index.

Top module: `tr_ring_consumer`

## Requirements
- R1: After synchronous reset, both indices read 0, `empty_o` is 1, `full_o` is 0, and neither `mem_req_valid` nor `dn_valid` is asserted.
- R2: While the engine is idle, `cfg_base_we`, `cfg_rd_we` and `cfg_wr_we` load the base, the consumer index and the producer index. While a descriptor is being fetched or offered, these writes are ignored, and an index value of `RING_LEN` or more is always ignored.
- R3: Programming the producer index through `cfg_wr_we` alone never starts a fetch. Work starts only after a doorbell.
- R4: A doorbell (`db_we`) with an index below `RING_LEN` replaces the producer index at the edge that samples it. If the ring is then non-empty and the engine is idle, `mem_req_valid` is high after the following rising edge.
- R5: The request address is `base + consumer_index * ELEM_BYTES`.
- R6: At most one memory read is outstanding. A request keeps `mem_req_valid` high with a stable address until `mem_req_ready` is sampled high, and no new request is issued until `mem_rsp_valid` returns the data.
- R7: The response data is offered on `dn_desc` with its index on `dn_idx`. `dn_valid` and the data hold until `dn_ready` is sampled high. The consumer index advances only on that acceptance, and it goes from `RING_LEN-1` to 0.
- R8: One cycle after each acceptance, `done_pulse` is high for exactly one cycle, and `done_idx` gives the index of the accepted descriptor.
- R9: `empty_o` is 1 exactly when the two indices are equal. `full_o` is 1 exactly when the producer index plus one, wrapped, equals the consumer index.
- R10: A doorbell that arrives while a descriptor is in flight is kept. Its new work is serviced after the current descriptor with no further doorbell.
- R11: Descriptors are serviced in ring order, one per index, until the consumer index equals the producer index. Then the engine goes idle.
- R12: A doorbell whose index is `RING_LEN` or more is ignored. The producer index is unchanged and no fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_we | input | 1 | Load ring base address |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_rd_we | input | 1 | Load consumer index |
| cfg_rd_idx | input | IDX_W | Consumer index value |
| cfg_wr_we | input | 1 | Load producer index (does not start work) |
| cfg_wr_idx | input | IDX_W | Producer index value |
| db_we | input | 1 | Doorbell write |
| db_wr_idx | input | IDX_W | New producer index carried by the doorbell |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DESC_W | Read data (descriptor) |
| dn_valid | output | 1 | Descriptor offered downstream |
| dn_ready | input | 1 | Downstream accepts descriptor |
| dn_desc | output | DESC_W | Offered descriptor |
| dn_idx | output | IDX_W | Ring index of offered descriptor |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_idx | output | IDX_W | Index of completed descriptor |
| rd_idx_o | output | IDX_W | Current consumer index |
| wr_idx_o | output | IDX_W | Current producer index |
| empty_o | output | 1 | Ring empty |
| full_o | output | 1 | Ring full |

## Verification
A doorbell sampled at edge k updates `wr_idx_o` and `empty_o`/`full_o` by the next falling edge. The first request appears after edge k+1. The bench checks both of these exactly at the falling edges that follow. A memory response is taken one cycle after the request handshake, and the descriptor is offered after the edge that captures it. The consumer process checks each descriptor and index at the falling edge just before the accepting edge. It then expects `done_pulse` with `done_idx` at the very next falling edge, and expects no strobe at any other time. Index, emptiness and ignored-write checks are made only once the engine has drained, or while it is deliberately held in the offer state.

// File: rtl/tr_pkg.sv
// Package: shared types of the descriptor ring consumer.
// Assumes: nothing beyond IEEE 1800-2017.
package tr_pkg;
    // Fetch sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_OFFER = 2'd3
    } fetch_state_e;
endpackage

// File: rtl/tr_ptr_regs.sv
// Module: ring context registers (base, consumer index, producer index),
// doorbell capture, wrap-around increment, and the empty/full tests.
// Assumes: RING_LEN >= 2; configuration writes are honoured only while
// the sequencer reports idle; index values >= RING_LEN are dropped.
module tr_ptr_regs #(
    parameter int RING_LEN = 6,
    parameter int IDX_W    = 3,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_rd_we,
    input  logic [IDX_W-1:0]  cfg_rd_idx,
    input  logic              cfg_wr_we,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              db_we,
    input  logic [IDX_W-1:0]  db_wr_idx,
    input  logic              advance,
    output logic [ADDR_W-1:0] base_q,
    output logic [IDX_W-1:0]  rd_q,
    output logic [IDX_W-1:0]  wr_q,
    output logic [IDX_W-1:0]  rd_next,
    output logic              empty,
    output logic              full,
    output logic              pending
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);
    localparam logic [IDX_W:0]   LEN_EXT  = (IDX_W+1)'(RING_LEN);

    logic              db_ok;
    logic              cfg_rd_ok;
    logic              cfg_wr_ok;
    logic [IDX_W-1:0]  wr_next;

    // Range qualification of every incoming index.
    always_comb begin
        db_ok     = db_we && ({1'b0, db_wr_idx} < LEN_EXT);
        cfg_rd_ok = idle && cfg_rd_we && ({1'b0, cfg_rd_idx} < LEN_EXT);
        cfg_wr_ok = idle && cfg_wr_we && ({1'b0, cfg_wr_idx} < LEN_EXT);
    end

    // Wrapped successors of both indices.
    always_comb begin
        rd_next = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
        wr_next = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    end

    // Occupancy tests.
    always_comb begin
        empty = (rd_q == wr_q);
        full  = (wr_next == rd_q);
    end

    // Base address register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (idle && cfg_base_we) begin
            base_q <= cfg_base;
        end
    end

    // Consumer index: host load while idle, step on downstream acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (advance) begin
            rd_q <= rd_next;
        end else if (cfg_rd_ok) begin
            rd_q <= cfg_rd_idx;
        end
    end

    // Producer index: the doorbell wins over a plain configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else if (db_ok) begin
            wr_q <= db_wr_idx;
        end else if (cfg_wr_ok) begin
            wr_q <= cfg_wr_idx;
        end
    end

    // Work-pending flag: armed by a doorbell, dropped once idle and drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (db_ok) begin
            pending <= 1'b1;
        end else if (idle && empty) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/tr_addr_gen.sv
// Module: descriptor address generator, base + index * ELEM_BYTES.
// Assumes: ELEM_BYTES >= 1; a power-of-two size is built as a shift,
// any other size as a constant multiply.
module tr_addr_gen #(
    parameter int IDX_W      = 3,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam bit IS_POW2 = ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0);
    localparam int SHIFT   = $clog2(ELEM_BYTES);

    logic [ADDR_W-1:0] offset;

    generate
        if (IS_POW2) begin : g_shift
            // Offset by shifting the index.
            always_comb offset = ADDR_W'(idx) << SHIFT;
        end else begin : g_mult
            // Offset by constant multiplication.
            always_comb offset = ADDR_W'(idx) * ADDR_W'(ELEM_BYTES);
        end
    endgenerate

    // Final byte address.
    always_comb addr = base + offset;
endmodule

// File: rtl/tr_fetch_seq.sv
// Module: fetch sequencer. Issues one memory read at a time, holds the
// returned descriptor for the downstream handshake, and signals the
// index advance and the completion strobe on acceptance.
// Assumes: the memory returns exactly one response per accepted request.
module tr_fetch_seq #(
    parameter int IDX_W  = 3,
    parameter int DESC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic              empty,
    input  logic              more,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DESC_W-1:0] dn_desc,
    output logic [IDX_W-1:0]  dn_idx,
    output logic              advance,
    output logic              idle,
    output logic              done_pulse,
    output logic [IDX_W-1:0]  done_idx
);
    import tr_pkg::*;

    fetch_state_e state_q, state_d;
    logic [DESC_W-1:0] desc_q;

    // Handshake outputs decoded from the state.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_REQ);
        dn_valid      = (state_q == ST_OFFER);
        advance       = dn_valid && dn_ready;
        dn_desc       = desc_q;
        dn_idx        = rd_idx;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pending && !empty) state_d = ST_REQ;
            ST_REQ:   if (mem_req_ready)     state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)     state_d = ST_OFFER;
            ST_OFFER: if (dn_ready)          state_d = more ? ST_REQ : ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor holding register, loaded by the memory response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            desc_q <= mem_rsp_data;
        end
    end

    // Completion strobe and index, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse <= 1'b0;
            done_idx   <= '0;
        end else begin
            done_pulse <= advance;
            if (advance) done_idx <= rd_idx;
        end
    end
endmodule

// File: rtl/tr_ring_consumer.sv
// Module: top of the doorbell-driven descriptor ring consumer. Connects the
// context registers, the address generator and the fetch sequencer.
// Assumes: RING_LEN >= 2, one channel, and a host that does not move the
// producer index past the consumer index.
module tr_ring_consumer #(
    parameter int RING_LEN   = 6,
    parameter int ADDR_W     = 32,
    parameter int DESC_W     = 64,
    parameter int ELEM_BYTES = 16,
    localparam int IDX_W     = $clog2(RING_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_rd_we,
    input  logic [IDX_W-1:0]  cfg_rd_idx,
    input  logic              cfg_wr_we,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              db_we,
    input  logic [IDX_W-1:0]  db_wr_idx,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DESC_W-1:0] dn_desc,
    output logic [IDX_W-1:0]  dn_idx,
    output logic              done_pulse,
    output logic [IDX_W-1:0]  done_idx,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic              empty_o,
    output logic              full_o
);
    logic              idle;
    logic              advance;
    logic              pending;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  rd_q;
    logic [IDX_W-1:0]  wr_q;
    logic [IDX_W-1:0]  rd_next;
    logic              more;

    tr_ptr_regs #(
        .RING_LEN (RING_LEN),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle        (idle),
        .cfg_base_we (cfg_base_we),
        .cfg_base    (cfg_base),
        .cfg_rd_we   (cfg_rd_we),
        .cfg_rd_idx  (cfg_rd_idx),
        .cfg_wr_we   (cfg_wr_we),
        .cfg_wr_idx  (cfg_wr_idx),
        .db_we       (db_we),
        .db_wr_idx   (db_wr_idx),
        .advance     (advance),
        .base_q      (base_q),
        .rd_q        (rd_q),
        .wr_q        (wr_q),
        .rd_next     (rd_next),
        .empty       (empty_o),
        .full        (full_o),
        .pending     (pending)
    );

    tr_addr_gen #(
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_addr (
        .base (base_q),
        .idx  (rd_q),
        .addr (mem_req_addr)
    );

    // More work remains after the descriptor currently offered.
    always_comb more = (rd_next != wr_q);

    tr_fetch_seq #(
        .IDX_W  (IDX_W),
        .DESC_W (DESC_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pending       (pending),
        .empty         (empty_o),
        .more          (more),
        .rd_idx        (rd_q),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_desc       (dn_desc),
        .dn_idx        (dn_idx),
        .advance       (advance),
        .idle          (idle),
        .done_pulse    (done_pulse),
        .done_idx      (done_idx)
    );

    // Observable index outputs.
    always_comb begin
        rd_idx_o = rd_q;
        wr_idx_o = wr_q;
    end
endmodule

// File: rtl/tr_ring_consumer_chk.sv
// Module: protocol checker for tr_ring_consumer, bound to every instance.
// Assumes: it observes only the ports of the top module.
module tr_ring_consumer_chk #(
    parameter int RING_LEN = 6,
    parameter int ADDR_W   = 32,
    parameter int DESC_W   = 64,
    parameter int IDX_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [DESC_W-1:0] dn_desc,
    input logic [IDX_W-1:0]  dn_idx,
    input logic              done_pulse,
    input logic [IDX_W-1:0]  done_idx,
    input logic [IDX_W-1:0]  rd_idx_o,
    input logic [IDX_W-1:0]  wr_idx_o,
    input logic              empty_o,
    input logic              full_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);
    localparam logic [IDX_W:0]   LEN_EXT  = (IDX_W+1)'(RING_LEN);

    logic outstanding;

    // Tracks an accepted read that has not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n)                             outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                  outstanding <= 1'b0;
    end

    p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_desc) && $stable(dn_idx)));

    p_advance_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |=>
            (rd_idx_o == (($past(dn_idx) == LAST_IDX) ? '0 : $past(dn_idx) + 1'b1)));

    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready) |=> (done_pulse && done_idx == $past(dn_idx)));

    p_no_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && dn_ready) |=> !done_pulse);

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    p_idx_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx_o} < LEN_EXT) && ({1'b0, wr_idx_o} < LEN_EXT));
endmodule

bind tr_ring_consumer tr_ring_consumer_chk #(
    .RING_LEN (RING_LEN),
    .ADDR_W   (ADDR_W),
    .DESC_W   (DESC_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .dn_valid      (dn_valid),
    .dn_ready      (dn_ready),
    .dn_desc       (dn_desc),
    .dn_idx        (dn_idx),
    .done_pulse    (done_pulse),
    .done_idx      (done_idx),
    .rd_idx_o      (rd_idx_o),
    .wr_idx_o      (wr_idx_o),
    .empty_o       (empty_o),
    .full_o        (full_o)
);

// File: tb/sim_tr_ring_consumer.sv
// Bench: sweeps the ring through a wrap, a full ring, back-pressure on both
// sides, busy-time doorbells and ignored writes; expected descriptors and
// indices are computed from the index arithmetic.
module sim_tr_ring_consumer;
    localparam int LEN    = 6;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int EB     = 16;
    localparam int IW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_base_we = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          cfg_rd_we = 1'b0;
    logic [IW-1:0] cfg_rd_idx = '0;
    logic          cfg_wr_we = 1'b0;
    logic [IW-1:0] cfg_wr_idx = '0;
    logic          db_we = 1'b0;
    logic [IW-1:0] db_wr_idx = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [DW-1:0] dn_desc;
    logic [IW-1:0] dn_idx;
    logic          done_pulse;
    logic [IW-1:0] done_idx;
    logic [IW-1:0] rd_idx_o;
    logic [IW-1:0] wr_idx_o;
    logic          empty_o;
    logic          full_o;

    int checks = 0;
    int fails = 0;
    int served = 0;
    int reqs = 0;
    int exp_rd = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit hold_all = 1'b0;
    bit finished = 1'b0;
    logic [AW-1:0] exp_base = '0;

    tr_ring_consumer #(
        .RING_LEN (LEN), .ADDR_W (AW), .DESC_W (DW), .ELEM_BYTES (EB)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_base_we (cfg_base_we), .cfg_base (cfg_base),
        .cfg_rd_we (cfg_rd_we), .cfg_rd_idx (cfg_rd_idx),
        .cfg_wr_we (cfg_wr_we), .cfg_wr_idx (cfg_wr_idx),
        .db_we (db_we), .db_wr_idx (db_wr_idx),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data), .dn_valid (dn_valid),
        .dn_ready (dn_ready), .dn_desc (dn_desc), .dn_idx (dn_idx),
        .done_pulse (done_pulse), .done_idx (done_idx),
        .rd_idx_o (rd_idx_o), .wr_idx_o (wr_idx_o),
        .empty_o (empty_o), .full_o (full_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [AW-1:0] elem_addr(input int idx);
        return exp_base + AW'(idx * EB);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Memory model: one response one cycle after each accepted request.
    initial begin
        bit pend = 1'b0;
        logic [AW-1:0] paddr = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = stall_mode ? ((cyc % 2) == 0) : 1'b1;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(paddr);
                pend = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                if (rst_n && mem_req_valid && mem_req_ready) begin
                    pend = 1'b1;
                    paddr = mem_req_addr;
                    reqs++;
                end
            end
        end
    end

    // Downstream consumer: checks order, content and completion strobes.
    initial begin
        bit want_done = 1'b0;
        int last_idx = 0;
        forever begin
            @(negedge clk);
            if (want_done) begin
                chk("R8 done_pulse", 64'(done_pulse), 64'd1);
                chk("R8 done_idx", 64'(done_idx), 64'(last_idx));
                want_done = 1'b0;
            end else if (rst_n && done_pulse) begin
                chk("R8 stray done_pulse", 64'(done_pulse), 64'd0);
            end
            dn_ready = hold_all ? 1'b0 : (stall_mode ? ((cyc % 3) == 0) : 1'b1);
            if (rst_n && dn_valid && dn_ready) begin
                chk("R11 dn_idx order", 64'(dn_idx), 64'(exp_rd));
                chk("R5 R7 dn_desc", 64'(dn_desc), 64'(mem_word(elem_addr(exp_rd))));
                last_idx = exp_rd;
                exp_rd = (exp_rd + 1) % LEN;
                served++;
                want_done = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic cfg_write(input int which, input logic [AW-1:0] val);
        @(negedge clk);
        case (which)
            0: begin cfg_base_we = 1'b1; cfg_base = val; end
            1: begin cfg_rd_we = 1'b1; cfg_rd_idx = IW'(val); end
            default: begin cfg_wr_we = 1'b1; cfg_wr_idx = IW'(val); end
        endcase
        @(negedge clk);
        cfg_base_we = 1'b0; cfg_rd_we = 1'b0; cfg_wr_we = 1'b0;
    endtask

    task automatic ring(input int val);
        @(negedge clk);
        db_we = 1'b1; db_wr_idx = IW'(val);
        @(negedge clk);
        db_we = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rd_idx_o == wr_idx_o && !dn_valid && !mem_req_valid) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int base_served;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 rd_idx", 64'(rd_idx_o), 64'd0);
        chk("R1 wr_idx", 64'(wr_idx_o), 64'd0);
        chk("R1 empty", 64'(empty_o), 64'd1);
        chk("R1 full", 64'(full_o), 64'd0);
        chk("R1 no request", 64'(mem_req_valid), 64'd0);
        chk("R1 no offer", 64'(dn_valid), 64'd0);
        rst_n = 1'b1;

        // R2 R3: program context; producer index alone starts nothing.
        exp_base = 32'h0000_1000;
        cfg_write(0, exp_base);
        cfg_write(2, 3);
        repeat (8) @(negedge clk);
        chk("R2 wr_idx loaded", 64'(wr_idx_o), 64'd3);
        chk("R3 no fetch without doorbell", 64'(reqs), 64'd0);
        chk("R9 not empty", 64'(empty_o), 64'd0);

        // R4: doorbell timing.
        @(negedge clk);
        db_we = 1'b1; db_wr_idx = 3'd3;
        @(negedge clk);
        db_we = 1'b0;
        chk("R4 no request before next edge", 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        chk("R4 request after next edge", 64'(mem_req_valid), 64'd1);
        chk("R5 request address", 64'(mem_req_addr), 64'(elem_addr(0)));
        drain();
        chk("R11 served three", 64'(served), 64'd3);
        chk("R11 rd caught up", 64'(rd_idx_o), 64'd3);
        chk("R9 empty after drain", 64'(empty_o), 64'd1);

        // R7: wrap with back-pressure on both sides.
        cfg_write(1, 4);
        exp_rd = 4;
        cfg_write(2, 4);
        stall_mode = 1'b1;
        base_served = served;
        ring(2);
        drain();
        chk("R7 wrap count", 64'(served - base_served), 64'd4);
        chk("R7 rd wrapped", 64'(rd_idx_o), 64'd2);

        // R9: full ring.
        stall_mode = 1'b0;
        chk("R9 not full before", 64'(full_o), 64'd0);
        base_served = served;
        ring(1);
        chk("R9 full", 64'(full_o), 64'd1);
        chk("R9 full not empty", 64'(empty_o), 64'd0);
        drain();
        chk("R11 full ring served", 64'(served - base_served), 64'd5);
        chk("R11 rd after full", 64'(rd_idx_o), 64'd1);

        // R2 R10: writes while busy; doorbell during offer.
        hold_all = 1'b1;
        base_served = served;
        ring(3);
        repeat (6) @(negedge clk);
        chk("R7 held offer", 64'(dn_valid), 64'd1);
        chk("R7 held idx", 64'(dn_idx), 64'd1);
        cfg_write(1, 5);
        cfg_write(0, 32'h0000_8000);
        chk("R2 rd write ignored while busy", 64'(rd_idx_o), 64'd1);
        ring(5);
        chk("R10 doorbell latched while busy", 64'(wr_idx_o), 64'd5);
        hold_all = 1'b0;
        drain();
        chk("R10 late work serviced", 64'(served - base_served), 64'd4);
        chk("R10 rd reaches new wr", 64'(rd_idx_o), 64'd5);

        // R12: out-of-range doorbell and configuration index ignored.
        base_served = reqs;
        ring(7);
        ring(6);
        repeat (6) @(negedge clk);
        chk("R12 wr unchanged", 64'(wr_idx_o), 64'd5);
        chk("R12 no fetch", 64'(reqs - base_served), 64'd0);
        cfg_write(1, 6);
        chk("R2 out-of-range rd ignored", 64'(rd_idx_o), 64'd5);

        // R6: one request per descriptor.
        chk("R6 requests equal descriptors", 64'(reqs), 64'(served));
        finish_run();
    end
endmodule